// File: doc/BRIEF.md
# Prioritized Dual-Output Interrupt Controller

The controller collects 64 peripheral request lines and presents the most urgent one to a processor on one of two outputs: a fast output for urgent work and a normal output for everything else. Every source carries a 3-bit priority. That priority picks the output (levels 0 and 1 go to the fast output, levels 2 to 7 go to the normal output) and also orders sources within the output. Level 0 is the most urgent and level 7 the least.

A request pulse is latched into a pending bit in the bank of its output class. It stays there until software writes a one to that bit. An enable bit per source gates which pending bits take part in arbitration. For each output, the winner's entry value is formed from a programmable base: base + 4 × (source + 1). The entry value is 0 when nothing qualifies. Software reaches all state through a plain 32-bit write strobe with byte offsets, and reads back through a combinational data port.

Top module: `intc_top`

## Requirements
- R1: After reset, every pending bit and every enable bit is 0, every priority is 7 (each priority register reads 0x77777777), both request outputs are low and both entry values are 0.
- R2: A request on source n is latched on the next clock edge. It goes into the fast pending bank (0x00 holds sources 0–31, 0x04 holds 32–63) when the source's priority is 0 or 1. Otherwise it goes into the normal pending bank (0x08 low half, 0x0C high half). The bit position is n mod 32.
- R3: Writing a pending register clears exactly the bits written as 1 and leaves the others unchanged.
- R4: When a request arrives in the same cycle as a write that clears its bit, the bit stays pending.
- R5: Enable bits sit at 0x18 (sources 0–31) and 0x1C (32–63), with bit n mod 32. An output is high only while its bank has a pending bit whose enable is 1. A disable takes effect on the output the cycle after the write and leaves the pending bit intact.
- R6: The priority of source n is held at offset 0x30 + 4·(n div 8), bits 4·(n mod 8) to 4·(n mod 8)+2. The fourth bit of each nibble reads 0 and ignores writes.
- R7: Within one output, the pending enabled source with the smallest priority value wins. Ties go to the lowest source number.
- R8: The base is read/write at 0x24, and 0 is a legal base. The entry value is base + 4·(winner + 1), or 0 when no source qualifies. The entry value drives the entry output and can be read at 0x10 (fast) and 0x14 (normal).
- R9: Offsets outside the map read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 64 | Request pulses, one per source |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| fiq_entry_o | output | 32 | Entry value of the fast winner |
| irq_entry_o | output | 32 | Entry value of the normal winner |

## Verification
The hardest case to reach from the ports is a request and a clear of the same pending bit landing on one clock edge. The bench drives the request line and the write strobe in the same low phase of the clock, then reads the bank back. Priority ties are the other hard case, in particular ties between sources in different banks, such as 31 against 32. Two-source vectors program equal levels on both sides of the bank boundary. Each vector starts from a cleared, all-level-7 state, so only the two programmed sources take part.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  parameter int NUM_SRC    = 64;
  parameter int WORD_W     = 32;
  parameter int PRIO_W     = 3;
  parameter int SLOT_W     = 4;
  parameter int ADDR_W     = 8;
  parameter int FIQ_LEVELS = 2;

  localparam int NUM_BANKS     = NUM_SRC / WORD_W;
  localparam int SLOTS         = WORD_W / SLOT_W;
  localparam int NUM_PRIO_REGS = NUM_SRC / SLOTS;
  localparam int IDX_W         = $clog2(NUM_SRC);
  localparam int NUM_OUT       = 2;

  localparam logic [ADDR_W-1:0] OFF_FPEND  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_IPEND  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_FENTRY = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_IENTRY = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_EN     = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_BASE   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_PRIO   = 8'h30;

  typedef enum int {OUT_FIQ = 0, OUT_IRQ = 1} out_sel_e;

  function automatic logic [ADDR_W-1:0] reg_at(input logic [ADDR_W-1:0] first, input int idx);
    return first + ADDR_W'(4 * idx);
  endfunction
endpackage

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs
  import intc_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [WORD_W-1:0]         wdata_i,
  output logic [NUM_SRC-1:0]        fiq_pend_o,
  output logic [NUM_SRC-1:0]        irq_pend_o,
  output logic [NUM_SRC-1:0]        en_o,
  output logic [NUM_SRC-1:0]        route_fiq_o,
  output logic [NUM_SRC*PRIO_W-1:0] prio_o,
  output logic [WORD_W-1:0]         base_o
);
  logic [NUM_SRC-1:0] fiq_pend_q, fiq_pend_d;
  logic [NUM_SRC-1:0] irq_pend_q, irq_pend_d;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] fiq_clr, irq_clr, route_fiq;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [WORD_W-1:0] base_q, base_d;

  // per-bank decode of pending clears and enable writes
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_f, hit_i, hit_e;
    assign hit_f = we_i && (addr_i == reg_at(OFF_FPEND, b));
    assign hit_i = we_i && (addr_i == reg_at(OFF_IPEND, b));
    assign hit_e = we_i && (addr_i == reg_at(OFF_EN, b));
    assign fiq_clr[b*WORD_W +: WORD_W] = hit_f ? wdata_i : '0;
    assign irq_clr[b*WORD_W +: WORD_W] = hit_i ? wdata_i : '0;
    assign en_d[b*WORD_W +: WORD_W]    = hit_e ? wdata_i : en_q[b*WORD_W +: WORD_W];
  end

  // per-source priority slot and output routing
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int REG_IDX  = n / SLOTS;
    localparam int SLOT_IDX = n % SLOTS;
    logic hit_p;
    assign hit_p     = we_i && (addr_i == reg_at(OFF_PRIO, REG_IDX));
    assign prio_d[n] = hit_p ? wdata_i[SLOT_IDX*SLOT_W +: PRIO_W] : prio_q[n];
    assign route_fiq[n] = prio_q[n] < PRIO_W'(FIQ_LEVELS);
  end

  // set wins over clear
  assign fiq_pend_d = (fiq_pend_q & ~fiq_clr) | (req_i & route_fiq);
  assign irq_pend_d = (irq_pend_q & ~irq_clr) | (req_i & ~route_fiq);
  assign base_d     = (we_i && (addr_i == OFF_BASE)) ? wdata_i : base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fiq_pend_q <= '0;
      irq_pend_q <= '0;
      en_q       <= '0;
      prio_q     <= '1;
      base_q     <= '0;
    end else begin
      fiq_pend_q <= fiq_pend_d;
      irq_pend_q <= irq_pend_d;
      en_q       <= en_d;
      prio_q     <= prio_d;
      base_q     <= base_d;
    end
  end

  assign fiq_pend_o  = fiq_pend_q;
  assign irq_pend_o  = irq_pend_q;
  assign en_o        = en_q;
  assign route_fiq_o = route_fiq;
  assign prio_o      = prio_q;
  assign base_o      = base_q;
endmodule

// File: rtl/intc_arb.sv
`timescale 1ns/1ps
module intc_arb
  import intc_pkg::*;
(
  input  logic [NUM_SRC-1:0]        cand_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [WORD_W-1:0]         base_i,
  output logic                      hit_o,
  output logic [WORD_W-1:0]         entry_o
);
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;
  logic              found;

  // scan downward with <= so the lowest index keeps ties
  always_comb begin
    found  = 1'b0;
    best_p = '1;
    best_i = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand_i[i] && (!found || (prio_i[i*PRIO_W +: PRIO_W] <= best_p))) begin
        found  = 1'b1;
        best_p = prio_i[i*PRIO_W +: PRIO_W];
        best_i = IDX_W'(i);
      end
    end
  end

  assign hit_o   = found;
  assign entry_o = found ? (base_i + ((WORD_W'(best_i) + WORD_W'(1)) << 2)) : '0;
endmodule

// File: rtl/intc_top.sv
`timescale 1ns/1ps
module intc_top
  import intc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               fiq_o,
  output logic               irq_o,
  output logic [WORD_W-1:0]  fiq_entry_o,
  output logic [WORD_W-1:0]  irq_entry_o
);
  logic [NUM_SRC-1:0]        fiq_pend, irq_pend, en_mask, route_fiq;
  logic [NUM_SRC*PRIO_W-1:0] prio;
  logic [WORD_W-1:0]         base;
  logic [NUM_OUT-1:0]        hit;
  logic [NUM_OUT-1:0][WORD_W-1:0] entry;

  intc_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .fiq_pend_o  (fiq_pend),
    .irq_pend_o  (irq_pend),
    .en_o        (en_mask),
    .route_fiq_o (route_fiq),
    .prio_o      (prio),
    .base_o      (base)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic [NUM_SRC-1:0] cand;
    if (g == OUT_FIQ) begin : g_fiq
      assign cand = fiq_pend & en_mask;
    end else begin : g_irq
      assign cand = irq_pend & en_mask;
    end
    intc_arb u_arb (
      .cand_i  (cand),
      .prio_i  (prio),
      .base_i  (base),
      .hit_o   (hit[g]),
      .entry_o (entry[g])
    );
  end

  assign fiq_o       = hit[OUT_FIQ];
  assign irq_o       = hit[OUT_IRQ];
  assign fiq_entry_o = entry[OUT_FIQ];
  assign irq_entry_o = entry[OUT_IRQ];

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_i == reg_at(OFF_FPEND, b)) rdata_o = fiq_pend[b*WORD_W +: WORD_W];
      if (addr_i == reg_at(OFF_IPEND, b)) rdata_o = irq_pend[b*WORD_W +: WORD_W];
      if (addr_i == reg_at(OFF_EN, b))    rdata_o = en_mask[b*WORD_W +: WORD_W];
    end
    for (int r = 0; r < NUM_PRIO_REGS; r++) begin
      if (addr_i == reg_at(OFF_PRIO, r)) begin
        for (int s = 0; s < SLOTS; s++) begin
          rdata_o[s*SLOT_W +: PRIO_W] = prio[(r*SLOTS + s)*PRIO_W +: PRIO_W];
        end
      end
    end
    if (addr_i == OFF_FENTRY) rdata_o = entry[OUT_FIQ];
    if (addr_i == OFF_IENTRY) rdata_o = entry[OUT_IRQ];
    if (addr_i == OFF_BASE)   rdata_o = base;
  end
endmodule

// File: rtl/intc_chk.sv
`timescale 1ns/1ps
module intc_chk
  import intc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [WORD_W-1:0]  wdata_i,
  input logic [NUM_SRC-1:0] fiq_pend,
  input logic [NUM_SRC-1:0] irq_pend,
  input logic [NUM_SRC-1:0] en_mask,
  input logic [NUM_SRC-1:0] route_fiq,
  input logic               fiq_o,
  input logic               irq_o,
  input logic [WORD_W-1:0]  fiq_entry_o,
  input logic [WORD_W-1:0]  irq_entry_o
);
  AST_FIQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i & route_fiq) != '0) |=> ((fiq_pend & $past(req_i & route_fiq)) == $past(req_i & route_fiq))); // R4
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i & ~route_fiq) != '0) |=> ((irq_pend & $past(req_i & ~route_fiq)) == $past(req_i & ~route_fiq))); // R2
  AST_W1C_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == OFF_IPEND)) |=> ((irq_pend[WORD_W-1:0] & $past(wdata_i & ~req_i[WORD_W-1:0])) == '0)); // R3
  AST_FIQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fiq_pend & en_mask) == '0) |-> !fiq_o); // R5
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_pend & en_mask) == '0) |-> !irq_o); // R5
  AST_FIQ_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fiq_o |-> (fiq_entry_o == '0)); // R8
  AST_IRQ_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_entry_o == '0)); // R8
endmodule

bind intc_top intc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .fiq_pend    (fiq_pend),
  .irq_pend    (irq_pend),
  .en_mask     (en_mask),
  .route_fiq   (route_fiq),
  .fiq_o       (fiq_o),
  .irq_o       (irq_o),
  .fiq_entry_o (fiq_entry_o),
  .irq_entry_o (irq_entry_o)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;
  logic        clk, rst_n, we;
  logic [63:0] req;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata, fentry, ientry;
  logic        fiq, irq;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [2:0]  shp [64];

  localparam logic [31:0] BASE = 32'h0000_1000;
  // {src_a[6], pa[3], src_b[6], pb[3], fiq_exp, fiq_win[6], irq_exp, irq_win[6]}
  localparam logic [31:0] VEC [6] = '{
    {6'd5,  3'd7, 6'd40, 3'd3, 1'b0, 6'd0,  1'b1, 6'd40},
    {6'd10, 3'd0, 6'd2,  3'd1, 1'b1, 6'd10, 1'b0, 6'd0},
    {6'd33, 3'd4, 6'd12, 3'd4, 1'b0, 6'd0,  1'b1, 6'd12},
    {6'd63, 3'd1, 6'd0,  3'd6, 1'b1, 6'd63, 1'b1, 6'd0},
    {6'd31, 3'd2, 6'd32, 3'd2, 1'b0, 6'd0,  1'b1, 6'd31},
    {6'd7,  3'd1, 6'd7,  3'd1, 1'b1, 6'd7,  1'b0, 6'd0}
  };

  intc_top dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .fiq_o(fiq), .irq_o(irq),
    .fiq_entry_o(fentry), .irq_entry_o(ientry)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [63:0] r);
    @(negedge clk);
    req = r;
    @(negedge clk);
    req = '0;
  endtask

  task automatic set_prio(input int n, input logic [2:0] p);
    logic [31:0] w;
    int r;
    shp[n] = p;
    r = n / 8;
    w = '0;
    for (int s = 0; s < 8; s++) w[s*4 +: 3] = shp[r*8 + s];
    wr(8'h30 + 8'(4*r), w);
  endtask

  task automatic prio_all7();
    for (int n = 0; n < 64; n++) shp[n] = 3'd7;
    for (int r = 0; r < 8; r++) wr(8'h30 + 8'(4*r), 32'h7777_7777);
  endtask

  task automatic clear_all();
    wr(8'h00, '1); wr(8'h04, '1); wr(8'h08, '1); wr(8'h0C, '1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, v, ef, ei;
    rst_n = 1'b0; we = 1'b0; req = '0; addr = '0; wdata = '0;
    for (int n = 0; n < 64; n++) shp[n] = 3'd7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 fiq_o", {31'd0, fiq}, 32'd0);
    chk("R1 irq_o", {31'd0, irq}, 32'd0);
    chk("R1 fiq entry", fentry, 32'd0);
    chk("R1 irq entry", ientry, 32'd0);
    rd(8'h18, d); chk("R1 enable low", d, 32'd0);
    rd(8'h1C, d); chk("R1 enable high", d, 32'd0);
    rd(8'h08, d); chk("R1 pending", d, 32'd0);
    rd(8'h30, d); chk("R1 prio first", d, 32'h7777_7777);
    rd(8'h4C, d); chk("R1 prio last", d, 32'h7777_7777);

    // table: R7 arbitration, R8 entry, R2 routing
    wr(8'h24, BASE);
    for (int k = 0; k < 6; k++) begin
      v = VEC[k];
      clear_all();
      prio_all7();
      set_prio(int'(v[31:26]), v[25:23]);
      set_prio(int'(v[22:17]), v[16:14]);
      wr(8'h18, '1); wr(8'h1C, '1);
      pulse((64'd1 << v[31:26]) | (64'd1 << v[22:17]));
      ef = v[13] ? BASE + 32'(4 * (int'(v[12:7]) + 1)) : 32'd0;
      ei = v[6]  ? BASE + 32'(4 * (int'(v[5:0]) + 1))  : 32'd0;
      chk($sformatf("R7 vec%0d fiq_o", k), {31'd0, fiq}, {31'd0, v[13]});
      chk($sformatf("R7 vec%0d irq_o", k), {31'd0, irq}, {31'd0, v[6]});
      chk($sformatf("R8 vec%0d fiq entry", k), fentry, ef);
      chk($sformatf("R8 vec%0d irq entry", k), ientry, ei);
      rd(8'h10, d); chk($sformatf("R8 vec%0d fiq entry read", k), d, ef);
      rd(8'h14, d); chk($sformatf("R8 vec%0d irq entry read", k), d, ei);
    end

    // R2 routing and bank placement, enables off
    wr(8'h18, '0); wr(8'h1C, '0);
    clear_all();
    prio_all7();
    wr(8'h24, 32'd0);
    set_prio(40, 3'd0);
    set_prio(3, 3'd5);
    pulse((64'd1 << 40) | (64'd1 << 3));
    rd(8'h04, d); chk("R2 fiq high bank", d, 32'h0000_0100);
    rd(8'h00, d); chk("R2 fiq low bank", d, 32'd0);
    rd(8'h08, d); chk("R2 irq low bank", d, 32'h0000_0008);
    rd(8'h0C, d); chk("R2 irq high bank", d, 32'd0);
    chk("R5 masked fiq", {31'd0, fiq}, 32'd0);
    chk("R5 masked irq", {31'd0, irq}, 32'd0);

    // R5 enable gating, R8 base zero
    wr(8'h1C, 32'h0000_0100);
    chk("R5 enabled fiq", {31'd0, fiq}, 32'd1);
    chk("R8 base zero entry", fentry, 32'd164);
    wr(8'h1C, 32'd0);
    chk("R5 disable immediate", {31'd0, fiq}, 32'd0);
    rd(8'h04, d); chk("R5 pending kept", d, 32'h0000_0100);

    // R3 write-one-to-clear
    pulse(64'd1 << 4);
    rd(8'h08, d); chk("R3 before clear", d, 32'h0000_0018);
    wr(8'h08, 32'h0000_0008);
    rd(8'h08, d); chk("R3 partial clear", d, 32'h0000_0010);
    rd(8'h04, d); chk("R3 other bank", d, 32'h0000_0100);

    // R4 set wins over clear
    @(negedge clk);
    req = 64'd1 << 4; addr = 8'h08; wdata = 32'h0000_0010; we = 1'b1;
    @(negedge clk);
    we = 1'b0; req = '0;
    rd(8'h08, d); chk("R4 set over clear", d, 32'h0000_0010);
    wr(8'h08, '1);
    rd(8'h08, d); chk("R3 clear all", d, 32'd0);

    // R6 priority slot layout
    wr(8'h34, '1);
    rd(8'h34, d); chk("R6 nibble top bit", d, 32'h7777_7777);
    wr(8'h34, 32'h8000_0001);
    rd(8'h34, d); chk("R6 slot write", d, 32'h0000_0001);
    prio_all7();

    // R9 unmapped offset
    wr(8'h24, 32'h0000_0ABC);
    wr(8'h20, '1);
    rd(8'h20, d); chk("R9 unmapped read", d, 32'd0);
    rd(8'h24, d); chk("R9 base untouched", d, 32'h0000_0ABC);
    rd(8'h18, d); chk("R9 enable untouched", d, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule